// File: doc/BRIEF.md
# Millisecond Interval Timer

A small timer peripheral that hangs on a simple processor bus: one shared address, write-data and write-enable from the processor, and one read-data bus back. A prescaler turns the system clock into a one-millisecond tick. Each tick advances a 32-bit counter. A second 32-bit register sets a wrap point. When the wrap point is zero the counter runs freely. Otherwise the counter returns to zero in place of reaching the wrap value.

Each wrap is recorded in a status register. The first unacknowledged wrap sets a ready flag. A wrap that arrives while ready is still set marks an overflow. Software acknowledges by writing zeros into those flag positions. An enable bit gates ready onto the interrupt line. Read data is zero unless the block is being read at one of its own addresses, so several devices can share a read bus through a plain OR.

Top module: `ms_timer`

## Requirements
- R1: After reset the counter, the wrap register and the status register all read 0, and `irq` is low.
- R2: The counter rises by exactly one per tick, and a tick occurs once every CLK_HZ/TICK_HZ clock cycles.
- R3: With the wrap register at 0 the counter never wraps early, rolls over from 0xFFFFFFFF to 0 and sets no flag.
- R4: With the wrap register at a nonzero L, a tick with the counter at L-1 loads 0, so counting alone never takes the counter to L or above.
- R5: A wrap sets ready (status bit 0) when ready is clear. When ready is already set, the wrap sets overflow (status bit 2) and ready stays 1.
- R6: A status write clears ready when data bit 0 is 0 and clears overflow when data bit 2 is 0. A 1 in either position changes nothing. Data bit 8 is stored as the interrupt enable and reads back at bit 8. All other status bits read as 0.
- R7: When a wrap and a status-clearing write fall in the same cycle, the wrap wins. Overflow is then judged on the ready value held before that cycle.
- R8: A bus write to the counter in a tick cycle loads the written value, and no wrap or flag change happens in that cycle.
- R9: `irq` is high exactly when ready and the interrupt enable are both 1.
- R10: With `bus_we` low, `bus_rdata` returns the counter at CNT_ADDR, the wrap register at LIM_ADDR and the status at CSR_ADDR, all 32 bits wide. It is 0 at any other address and during any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address from the processor |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable; a low value means a read |
| bus_rdata | output | 32 | Read data, zero when not selected |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CLK_HZ = 10000 and TICK_HZ = 1000, so a tick comes every ten clocks. Wraps at small limits, repeated wraps that produce overflow, and the 32-bit rollover after a preload near the top all fall within a few hundred cycles. The short period also lets the bench line up a counter write or a flag clear with the exact cycle of a pending wrap, which makes the R7 and R8 collisions repeatable.

// File: rtl/ms_timer.sv
module ms_timer #(
  parameter int          DATA_W   = 32,
  parameter int          CLK_HZ   = 50_000_000,
  parameter int          TICK_HZ  = 1000,
  parameter logic [31:0] CNT_ADDR = 32'hF000_0020,
  parameter logic [31:0] LIM_ADDR = 32'hF000_0024,
  parameter logic [31:0] CSR_ADDR = 32'hF000_0120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(DIV - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] cnt_q, lim_q;
  logic              rdy_q, ovf_q, ie_q;

  wire tick   = (pre_q == PRE_MAX);
  wire sel_c  = (bus_addr == CNT_ADDR);
  wire sel_l  = (bus_addr == LIM_ADDR);
  wire sel_s  = (bus_addr == CSR_ADDR);
  wire wr_cnt = bus_we && sel_c;
  wire wr_lim = bus_we && sel_l;
  wire wr_csr = bus_we && sel_s;
  wire at_end = (lim_q != '0) && (cnt_q == lim_q - 1'b1);
  wire wrap   = tick && !wr_cnt && at_end;

  wire [DATA_W-1:0] csr_view = DATA_W'({ie_q, 5'b0, ovf_q, 1'b0, rdy_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (wrap)   cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (wr_lim) lim_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovf_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      rdy_q <= (rdy_q && !(wr_csr && !bus_wdata[0])) || wrap;
      ovf_q <= (ovf_q && !(wr_csr && !bus_wdata[2])) || (wrap && rdy_q);
      if (wr_csr) ie_q <= bus_wdata[8];
    end
  end

  assign irq = rdy_q && ie_q;

  assign bus_rdata = bus_we ? '0 :
                     sel_c  ? cnt_q :
                     sel_l  ? lim_q :
                     sel_s  ? csr_view : '0;

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0) && rdy_q);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt_q));

  // R3
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && lim_q == '0) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R5
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(rdy_q));

  // R5
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(rdy_q));

  // R8
  load_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(bus_wdata));

  // R10
  quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_rdata == '0);
endmodule

// File: tb/sim_ms_timer.sv
module sim_ms_timer;
  localparam int CLK_HZ = 10_000;
  localparam int TICK_HZ = 1000;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam logic [31:0] A_CNT = 32'hF000_0020;
  localparam logic [31:0] A_LIM = 32'hF000_0024;
  localparam logic [31:0] A_CSR = 32'hF000_0120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] addr = 32'h0;
  logic [31:0] wdata = 32'h0;
  logic we = 1'b0;
  logic [31:0] rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ms_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ),
             .CNT_ADDR(A_CNT), .LIM_ADDR(A_LIM), .CSR_ADDR(A_CSR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .irq(irq));

  int unsigned m_pre;
  logic [31:0] m_cnt, m_lim;
  bit m_rdy, m_ovf, m_ie;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_lim = 0; m_rdy = 0; m_ovf = 0; m_ie = 0;
    end else begin
      bit t, w, old_rdy;
      t = (m_pre == DIV - 1);
      m_pre = t ? 0 : m_pre + 1;
      w = 0;
      if (we && addr == A_CNT) m_cnt = wdata;
      else if (t) begin
        if (m_lim != 0 && m_cnt == m_lim - 1) begin m_cnt = 0; w = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (we && addr == A_LIM) m_lim = wdata;
      old_rdy = m_rdy;
      if (we && addr == A_CSR) begin
        if (!wdata[0]) m_rdy = 0;
        if (!wdata[2]) m_ovf = 0;
        m_ie = wdata[8];
      end
      if (w) begin
        if (old_rdy) m_ovf = 1;
        m_rdy = 1;
      end
    end
  end

  function automatic logic [31:0] model_rd();
    if (we) return 32'h0;
    if (addr == A_CNT) return m_cnt;
    if (addr == A_LIM) return m_lim;
    if (addr == A_CSR) return {23'h0, m_ie, 5'h0, m_ovf, 1'b0, m_rdy};
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata == model_rd(), "R10 per-cycle read data", rdata, model_rd());
      chk(irq == (m_rdy && m_ie), "R9 per-cycle irq", 32'(irq), 32'(m_rdy && m_ie));
    end
  end

  task automatic put(input logic [31:0] a, input logic [31:0] d, input bit w);
    addr = a; wdata = d; we = w;
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] d, input bit w);
    @(posedge clk); #1;
    put(a, d, w);
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string tag);
    drive(a, 0, 0);
    @(negedge clk);
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic wait_wrap();
    do begin
      @(posedge clk); #1;
      we = 0;
    end while (!((m_pre == DIV - 1) && m_lim != 0 && m_cnt == m_lim - 1));
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(A_CNT, 32'h0, "R1 counter reset");
    rd_chk(A_LIM, 32'h0, "R1 limit reset");
    rd_chk(A_CSR, 32'h0, "R1 status reset");
    chk(irq == 1'b0, "R1 irq reset", 32'(irq), 32'h0);

    // R2 tick rate: 50 cycles hold exactly five ticks
    drive(A_CNT, 32'd100, 1);
    drive(A_CNT, 0, 0);
    @(negedge clk); v1 = rdata;
    repeat (50) @(negedge clk);
    v2 = rdata;
    chk(v2 - v1 == 32'd5, "R2 five ticks in fifty cycles", v2 - v1, 32'd5);

    // R4 and R5 with limit 3
    drive(A_LIM, 32'd3, 1);
    drive(A_CNT, 32'd0, 1);
    drive(A_CNT, 0, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      chk(rdata < 32'd3, "R4 counter below limit", rdata, 32'd2);
    end
    drive(A_LIM, 32'd0, 1);
    rd_chk(A_CSR, 32'h5, "R5 ready and overflow after repeated wraps");
    chk(irq == 1'b0, "R9 irq off without enable", 32'(irq), 32'h0);

    // R6 write-zero clears, write-one ignored, enable
    drive(A_CSR, 32'hFFFF_FFFF, 1);
    rd_chk(A_CSR, 32'h105, "R6 ones leave flags, set enable");
    chk(irq == 1'b1, "R9 irq with ready and enable", 32'(irq), 32'h1);
    drive(A_CSR, 32'hFFFF_FEFF, 1);
    rd_chk(A_CSR, 32'h005, "R6 enable cleared");
    chk(irq == 1'b0, "R9 irq gated by enable", 32'(irq), 32'h0);
    drive(A_CSR, 32'h0000_0104, 1);
    rd_chk(A_CSR, 32'h104, "R6 clear ready only");
    drive(A_CSR, 32'h0000_0100, 1);
    rd_chk(A_CSR, 32'h100, "R6 clear overflow");

    // R7 wrap against a clear in the same cycle
    drive(A_LIM, 32'd2, 1);
    drive(A_CNT, 32'd0, 1);
    wait_wrap();
    drive(A_CSR, 0, 0);
    @(negedge clk);
    chk(rdata == 32'h101, "R5 first wrap sets ready only", rdata, 32'h101);
    wait_wrap();
    put(A_CSR, 32'h100, 1);
    rd_chk(A_CSR, 32'h105, "R7 wrap wins over clear");
    chk(irq == 1'b1, "R9 irq after wrap", 32'(irq), 32'h1);

    // R8 counter write beats a pending wrap
    drive(A_CSR, 32'h0, 1);
    wait_wrap();
    put(A_CNT, 32'd1, 1);
    rd_chk(A_CSR, 32'h0, "R8 no event when counter written");
    rd_chk(A_CNT, 32'd1, "R8 written value kept");

    // R3 free run through rollover
    drive(A_LIM, 32'd0, 1);
    drive(A_CNT, 32'hFFFF_FFFE, 1);
    drive(A_CNT, 0, 0);
    repeat (40) @(negedge clk);
    chk(rdata < 32'd5, "R3 counter rolled over", rdata, 32'd2);
    rd_chk(A_CSR, 32'h0, "R3 no flag without limit");

    // R10 decode and width
    drive(A_LIM, 32'hDEAD_BEEF, 1);
    @(negedge clk);
    chk(rdata == 32'h0, "R10 zero during write", rdata, 32'h0);
    rd_chk(A_LIM, 32'hDEAD_BEEF, "R10 limit full width");
    rd_chk(32'hF000_0028, 32'h0, "R10 unmapped address");
    drive(A_CNT, 32'h1234_5678, 1);
    drive(A_CNT, 0, 0);
    @(negedge clk);
    chk(rdata - 32'h1234_5678 < 32'd2, "R10 counter full width", rdata, 32'h1234_5678);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule